// File: doc/BRIEF.md
# Event-Driven Three-Layer Spiking Core

A small spiking neural network core with three layers of integrate-and-fire neurons: an input layer, a hidden layer and an output layer of 16 neurons. Spikes enter as input-neuron addresses on a valid/ready port. Each input neuron owns a short list of synapse slots; every valid slot names one hidden neuron and a signed weight. The core walks those slots one at a time. For each slot it fetches the entry, adds the weight to the target's saturating accumulator, compares the sum with the layer threshold, and on firing clears the accumulator and routes a spike onward.

Hidden spikes go into a small internal queue. Each queued hidden spike is then handled the same way, using the hidden layer's own slot table, and reaches the output neurons. Output spikes leave as 4-bit neuron addresses on a valid/ready port. No new input event is taken until the queue is empty, so the order of spikes is fixed by the order of inputs and slots. With no event pending the core does nothing. Synapse entries and the two layer thresholds are loaded through a configuration write port that accepts writes only while the core is idle.

Top module: `spike_core`

## Requirements
- R1: After reset, outValid is 0 while inReady and cfgReady are 1; every synapse slot is invalid and both thresholds are 32767.
- R2: A configuration write stores cfgData at cfgAddr. cfgSel 0 selects the input-layer slot table and cfgSel 1 the hidden-layer slot table, both addressed as source*4+slot. cfgSel 2 selects a threshold: cfgAddr[0]=0 for the hidden layer, 1 for the output layer. A slot entry holds a signed weight in bits [7:0], the target neuron in bits [13:8] and a valid flag in bit 14. A threshold is a signed 16-bit value.
- R3: cfgReady is 1 only while the core is idle with an empty hidden queue. A write offered while cfgReady is 0 has no effect.
- R4: inReady is 1 only while the core is idle, the hidden queue is empty and no configuration write is offered. inReady is 0 from the cycle after an accepted event until all processing caused by that event is done.
- R5: A valid slot adds its weight to the target accumulator. The target fires when its accumulator is greater than or equal to its layer's threshold.
- R6: A neuron that fires has its accumulator cleared to zero in the cycle its spike is emitted.
- R7: Accumulators saturate at -32768 and 32767 instead of wrapping.
- R8: Hidden spikes are queued in the order they fire and are processed in that order before the next input event is accepted. The output spikes keep that order.
- R9: While outReady is 0, outValid stays 1 with a stable outAddr, and the core stalls until the spike is taken.
- R10: Invalid slots produce no update. No output spike is produced without an input event.
- R11: Each valid slot takes four cycles (fetch, accumulate, compare, emit), each invalid slot one cycle, and starting a queued hidden spike one cycle. For a default-configured input event whose slot 1 fires a hidden neuron whose slot 0 fires an output neuron, outValid rises 15 cycles after the input handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input spike offered |
| inReady | output | 1 | Core accepts an input spike |
| inAddr | input | 8 | Input neuron address |
| outValid | output | 1 | Output spike pending |
| outReady | input | 1 | Receiver takes the output spike |
| outAddr | output | 4 | Output neuron address |
| cfgValid | input | 1 | Configuration write offered |
| cfgReady | output | 1 | Configuration write accepted this cycle |
| cfgSel | input | 2 | Target of the write: input slots, hidden slots, threshold |
| cfgAddr | input | 10 | Slot address or threshold select |
| cfgData | input | 16 | Slot entry or threshold value |

## Verification
A wrong accumulator value is hidden at first. It shows only when a later event should or should not make that neuron fire, so the bench drives repeated events into the same neurons. This exposes a missed clear after firing on the third event and a wrapped sum just past the negative limit. A queue or slot-walk fault changes the order of output addresses or the cycle in which outValid rises, and both are checked on the exact cycle. A configuration write that slips in while the core is busy shows up only when its source is stimulated later, so that case is replayed after the busy period.

// File: rtl/spike_core_pkg.sv
package spike_core_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FETCH,
    PH_ACCUM,
    PH_CMP,
    PH_EMIT
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgWr;
    logic startExt;
    logic startHid;
    logic loadEnt;
    logic accum;
    logic compare;
    logic emit;
  } strobe_t;

  localparam logic [1:0] SEL_IN_SYN  = 2'd0;
  localparam logic [1:0] SEL_HID_SYN = 2'd1;
  localparam logic [1:0] SEL_THRESH  = 2'd2;

endpackage

// File: rtl/spike_core_fifo.sv
module spike_core_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [DW-1:0] pushData,
  input  logic          pop,
  output logic [DW-1:0] headData,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [PW:0]   count;

  assign empty    = (count == '0);
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        store[wrPtr] <= pushData;
        wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (pop) rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + (PW+1)'(push) - (PW+1)'(pop);
    end
  end
endmodule

// File: rtl/spike_core_ctrl.sv
module spike_core_ctrl
  import spike_core_pkg::*;
#(
  parameter int FANOUT = 4,
  localparam int SLW = $clog2(FANOUT)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic           cfgValid,
  input  logic           fifoEmpty,
  input  logic           entValid,
  input  logic           emitStall,
  output logic           inReady,
  output logic           cfgReady,
  output logic [SLW-1:0] slot,
  output strobe_t        stb
);
  phase_t phase, phaseNext;
  logic [SLW-1:0] slotNext;
  logic idleFree, lastSlot;

  assign idleFree = (phase == PH_IDLE) && fifoEmpty;
  assign cfgReady = idleFree;
  assign inReady  = idleFree && !cfgValid;
  assign lastSlot = (slot == SLW'(FANOUT - 1));

  always_comb begin
    stb          = '0;
    stb.cfgWr    = cfgValid && idleFree;
    stb.startExt = inValid && inReady;
    stb.startHid = (phase == PH_IDLE) && !fifoEmpty;
    stb.loadEnt  = (phase == PH_FETCH) && entValid;
    stb.accum    = (phase == PH_ACCUM);
    stb.compare  = (phase == PH_CMP);
    stb.emit     = (phase == PH_EMIT) && !emitStall;
  end

  always_comb begin
    phaseNext = phase;
    slotNext  = slot;
    unique case (phase)
      PH_IDLE: if (stb.startExt || stb.startHid) begin
        phaseNext = PH_FETCH;
        slotNext  = '0;
      end
      PH_FETCH: begin
        if (entValid) phaseNext = PH_ACCUM;
        else if (lastSlot) phaseNext = PH_IDLE;
        else slotNext = slot + 1'b1;
      end
      PH_ACCUM: phaseNext = PH_CMP;
      PH_CMP:   phaseNext = PH_EMIT;
      PH_EMIT: if (!emitStall) begin
        if (lastSlot) phaseNext = PH_IDLE;
        else begin
          phaseNext = PH_FETCH;
          slotNext  = slot + 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      slot  <= '0;
    end else begin
      phase <= phaseNext;
      slot  <= slotNext;
    end
  end
endmodule

// File: rtl/spike_core_dp.sv
module spike_core_dp
  import spike_core_pkg::*;
#(
  parameter int NIN    = 256,
  parameter int NHID   = 64,
  parameter int NOUT   = 16,
  parameter int FANOUT = 4,
  parameter int WW     = 8,
  parameter int AW     = 16,
  localparam int INW   = $clog2(NIN),
  localparam int HIDW  = $clog2(NHID),
  localparam int OUTW  = $clog2(NOUT),
  localparam int SLW   = $clog2(FANOUT),
  localparam int EW    = 1 + HIDW + WW,
  localparam int INDEPTH = NIN * FANOUT,
  localparam int HDDEPTH = NHID * FANOUT,
  localparam int CAW   = $clog2(INDEPTH),
  localparam int HDAW  = $clog2(HDDEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [SLW-1:0]  slot,
  input  logic [INW-1:0]  inAddr,
  input  logic [1:0]      cfgSel,
  input  logic [CAW-1:0]  cfgAddr,
  input  logic [AW-1:0]   cfgData,
  input  logic            outReady,
  output logic            outValid,
  output logic [OUTW-1:0] outAddr,
  output logic            entValid,
  output logic            emitStall,
  output logic            fifoEmpty
);
  localparam logic signed [AW-1:0] ACC_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] ACC_MIN = {1'b1, {(AW-1){1'b0}}};

  function automatic logic signed [AW-1:0] satAdd(input logic signed [AW-1:0] a,
                                                  input logic signed [WW-1:0] b);
    logic signed [AW:0] s;
    s = {a[AW-1], a} + {{(AW+1-WW){b[WW-1]}}, b};
    if (s[AW] != s[AW-1]) return s[AW] ? ACC_MIN : ACC_MAX;
    return s[AW-1:0];
  endfunction

  logic [EW-1:0] inSyn  [INDEPTH];
  logic [EW-1:0] hidSyn [HDDEPTH];
  logic signed [AW-1:0] hidAcc [NHID];
  logic signed [AW-1:0] outAcc [NOUT];
  logic signed [AW-1:0] thrHid, thrOut;

  logic [INW-1:0]  srcReg;
  logic            layerReg;   // 0: input->hidden, 1: hidden->output
  logic [HIDW-1:0] tgtReg;
  logic signed [WW-1:0] wReg;
  logic            fireReg;

  logic [EW-1:0]   lkEntry;
  logic [HIDW-1:0] fifoHead;
  logic            fifoPush;
  logic signed [AW-1:0] curAcc, curThr;
  logic [OUTW-1:0] tgtOut;

  assign tgtOut = tgtReg[OUTW-1:0];
  assign lkEntry = layerReg ? hidSyn[{srcReg[HIDW-1:0], slot}] : inSyn[{srcReg, slot}];
  assign entValid = lkEntry[EW-1];
  assign curAcc = layerReg ? outAcc[tgtOut] : hidAcc[tgtReg];
  assign curThr = layerReg ? thrOut : thrHid;
  assign emitStall = fireReg && layerReg && outValid && !outReady;
  assign fifoPush = stb.emit && fireReg && !layerReg;

  spike_core_fifo #(.DEPTH(FANOUT), .DW(HIDW)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (fifoPush),
    .pushData (tgtReg),
    .pop      (stb.startHid),
    .headData (fifoHead),
    .empty    (fifoEmpty)
  );

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < INDEPTH; i++) inSyn[i] <= '0;
      for (int i = 0; i < HDDEPTH; i++) hidSyn[i] <= '0;
      thrHid <= ACC_MAX;
      thrOut <= ACC_MAX;
    end else if (stb.cfgWr) begin
      unique case (cfgSel)
        SEL_IN_SYN:  inSyn[cfgAddr] <= cfgData[EW-1:0];
        SEL_HID_SYN: hidSyn[cfgAddr[HDAW-1:0]] <= cfgData[EW-1:0];
        SEL_THRESH: begin
          if (cfgAddr[0]) thrOut <= cfgData;
          else thrHid <= cfgData;
        end
        default: ;
      endcase
    end
  end

  // event context and slot entry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg   <= '0;
      layerReg <= 1'b0;
      tgtReg   <= '0;
      wReg     <= '0;
      fireReg  <= 1'b0;
    end else begin
      if (stb.startExt) begin
        srcReg   <= inAddr;
        layerReg <= 1'b0;
      end else if (stb.startHid) begin
        srcReg   <= INW'(fifoHead);
        layerReg <= 1'b1;
      end
      if (stb.loadEnt) begin
        tgtReg <= lkEntry[EW-2:WW];
        wReg   <= lkEntry[WW-1:0];
      end
      if (stb.compare) fireReg <= (curAcc >= curThr);
    end
  end

  // accumulators
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NHID; i++) hidAcc[i] <= '0;
      for (int i = 0; i < NOUT; i++) outAcc[i] <= '0;
    end else if (stb.accum) begin
      if (layerReg) outAcc[tgtOut] <= satAdd(outAcc[tgtOut], wReg);
      else hidAcc[tgtReg] <= satAdd(hidAcc[tgtReg], wReg);
    end else if (stb.emit && fireReg) begin
      if (layerReg) outAcc[tgtOut] <= '0;
      else hidAcc[tgtReg] <= '0;
    end
  end

  // output spike register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
    end else if (stb.emit && fireReg && layerReg) begin
      outValid <= 1'b1;
      outAddr  <= tgtOut;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/spike_core.sv
module spike_core
  import spike_core_pkg::*;
#(
  parameter int NIN    = 256,
  parameter int NHID   = 64,
  parameter int NOUT   = 16,
  parameter int FANOUT = 4,
  parameter int WW     = 8,
  parameter int AW     = 16,
  localparam int INW   = $clog2(NIN),
  localparam int OUTW  = $clog2(NOUT),
  localparam int SLW   = $clog2(FANOUT),
  localparam int CAW   = $clog2(NIN * FANOUT)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output logic            inReady,
  input  logic [INW-1:0]  inAddr,
  output logic            outValid,
  input  logic            outReady,
  output logic [OUTW-1:0] outAddr,
  input  logic            cfgValid,
  output logic            cfgReady,
  input  logic [1:0]      cfgSel,
  input  logic [CAW-1:0]  cfgAddr,
  input  logic [AW-1:0]   cfgData
);
  strobe_t        stb;
  logic [SLW-1:0] slot;
  logic           entValid, emitStall, fifoEmpty;

  spike_core_ctrl #(.FANOUT(FANOUT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .cfgValid  (cfgValid),
    .fifoEmpty (fifoEmpty),
    .entValid  (entValid),
    .emitStall (emitStall),
    .inReady   (inReady),
    .cfgReady  (cfgReady),
    .slot      (slot),
    .stb       (stb)
  );

  spike_core_dp #(
    .NIN(NIN), .NHID(NHID), .NOUT(NOUT), .FANOUT(FANOUT), .WW(WW), .AW(AW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .slot      (slot),
    .inAddr    (inAddr),
    .cfgSel    (cfgSel),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .outReady  (outReady),
    .outValid  (outValid),
    .outAddr   (outAddr),
    .entValid  (entValid),
    .emitStall (emitStall),
    .fifoEmpty (fifoEmpty)
  );
endmodule

// File: rtl/spike_core_chk.sv
module spike_core_chk #(
  parameter int INW  = 8,
  parameter int OUTW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic            inReady,
  input logic            outValid,
  input logic            outReady,
  input logic [OUTW-1:0] outAddr,
  input logic            cfgValid,
  input logic            cfgReady
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outAddr)); // R9

  AST_IN_IMPLIES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> cfgReady); // R4

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !inReady && !cfgReady); // R3

  AST_CFG_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> !inReady); // R4

  AST_SPIKE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(!cfgReady)); // R10
endmodule

bind spike_core spike_core_chk #(.INW(INW), .OUTW(OUTW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outAddr  (outAddr),
  .cfgValid (cfgValid),
  .cfgReady (cfgReady)
);

// File: tb/spike_core_bench.sv
module spike_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inAddr = '0;
  logic outReady = 1'b1;
  logic cfgValid = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [9:0] cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic inReady, outValid, cfgReady;
  logic [3:0] outAddr;

  int checks = 0;
  int failures = 0;
  int capCnt = 0;
  logic [3:0] capAddr [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  spike_core u_spike_core (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inAddr(inAddr),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr),
    .cfgValid(cfgValid), .cfgReady(cfgReady), .cfgSel(cfgSel),
    .cfgAddr(cfgAddr), .cfgData(cfgData)
  );

  // {source, expected output count, expected first output address}
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd1, 4'd0, 4'd0},   // R5: hidden 1 reaches 11 and fires, output 7 only at 10
    {8'd1, 4'd0, 4'd0},   // R6: hidden 1 restarted at 0, now 5
    {8'd1, 4'd1, 4'd7},   // R5 R6: hidden 1 at 10 fires, output 7 reaches 20
    {8'd0, 4'd1, 4'd5},   // R8: hidden 2 fires, output 5 fires
    {8'd6, 4'd0, 4'd0}    // R10: source with no valid slot
  };

  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (capCnt < 16) capAddr[capCnt] = outAddr;
      capCnt = capCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] synEntry(input int tgt, input int w);
    return {1'b0, 1'b1, 6'(tgt), 8'(w)};
  endfunction

  task automatic cfgWrite(input logic [1:0] sel, input int addr, input logic [15:0] data);
    @(negedge clk);
    cfgValid = 1'b1; cfgSel = sel; cfgAddr = 10'(addr); cfgData = data;
    while (!cfgReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  task automatic sendEvent(input int src);
    @(negedge clk);
    inValid = 1'b1; inAddr = 8'(src);
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!(inReady && !outValid)) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R1 inReady after reset", int'(inReady), 1);
    check(cfgReady == 1'b1, "R1 cfgReady after reset", int'(cfgReady), 1);

    // R2: thresholds and slot tables
    cfgWrite(2'd2, 0, 16'd10);
    cfgWrite(2'd2, 1, 16'd20);
    cfgWrite(2'd0, 0,  synEntry(1, 6));
    cfgWrite(2'd0, 1,  synEntry(2, 12));
    cfgWrite(2'd0, 4,  synEntry(1, 5));
    for (int s = 0; s < 4; s++) cfgWrite(2'd0, 8 + s, synEntry(3, -128));
    cfgWrite(2'd0, 16, synEntry(2, 12));
    cfgWrite(2'd0, 17, synEntry(5, 12));
    cfgWrite(2'd1, 4,  synEntry(7, 10));
    cfgWrite(2'd1, 8,  synEntry(5, 25));
    cfgWrite(2'd1, 12, synEntry(9, 127));
    cfgWrite(2'd1, 20, synEntry(11, 30));

    // R10: idle without events
    repeat (10) @(negedge clk);
    check(!outValid && inReady, "R10 idle no spike", int'(outValid), 0);

    // R11: latency of source 0 through hidden 2 to output 5
    capCnt = 0;
    sendEvent(0);
    check(inReady == 1'b0, "R4 busy after accept", int'(inReady), 0);
    repeat (14) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R11 not yet at cycle 14", int'(outValid), 0);
    @(negedge clk);
    check(outValid == 1'b1, "R11 outValid at cycle 15", int'(outValid), 1);
    check(outAddr == 4'd5, "R11 output address", int'(outAddr), 5);
    waitIdle();
    check(capCnt == 1, "R5 one output for first event", capCnt, 1);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      capCnt = 0;
      sendEvent(int'(VEC[v][15:8]));
      waitIdle();
      check(capCnt == int'(VEC[v][7:4]), "R5 R6 R10 output count", capCnt, int'(VEC[v][7:4]));
      if (VEC[v][7:4] != 0)
        check(capAddr[0] == VEC[v][3:0], "R5 R8 output address", int'(capAddr[0]), int'(VEC[v][3:0]));
    end

    // R9 R8 R3: backpressure, two ordered outputs, write while busy
    capCnt = 0;
    outReady = 1'b0;
    sendEvent(4);
    @(negedge clk);
    while (!outValid) @(negedge clk);
    check(outAddr == 4'd5, "R8 first queued output", int'(outAddr), 5);
    cfgValid = 1'b1; cfgSel = 2'd0; cfgAddr = 10'd20; cfgData = synEntry(2, 12);
    check(cfgReady == 1'b0, "R3 cfgReady low while busy", int'(cfgReady), 0);
    @(negedge clk);
    cfgValid = 1'b0;
    repeat (8) @(negedge clk);
    check(outValid == 1'b1, "R9 outValid held", int'(outValid), 1);
    check(outAddr == 4'd5, "R9 outAddr held", int'(outAddr), 5);
    check(inReady == 1'b0, "R9 core stalled", int'(inReady), 0);
    outReady = 1'b1;
    waitIdle();
    check(capCnt == 2, "R8 two outputs", capCnt, 2);
    check(capAddr[0] == 4'd5, "R8 order first", int'(capAddr[0]), 5);
    check(capAddr[1] == 4'd11, "R8 order second", int'(capAddr[1]), 11);

    // R3: rejected write left source 5 empty
    capCnt = 0;
    sendEvent(5);
    waitIdle();
    check(capCnt == 0, "R3 busy write ignored", capCnt, 0);

    // R7: drive hidden 3 far below the negative limit
    capCnt = 0;
    for (int k = 0; k < 70; k++) begin
      sendEvent(2);
      waitIdle();
    end
    check(capCnt == 0, "R7 negative saturation", capCnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule